// File: doc/BRIEF.md
# Bus-Mapped Sample FIFO Playback Controller

This block lets an 8-bit host play audio by writing sample bytes to a memory-mapped port. The bytes collect in a small FIFO. A rate generator runs from the host bus clock E and periodically raises a shift-out strobe. Each strobe moves the oldest sample onto a registered DAC data output.

The host reaches the block through two addresses. Address 0 is the data port. A write to it pushes a sample, and a read from it returns the FIFO status. Address 1 is a 3-bit control register. The control register picks one of four playback rates and can halt playback.

Halting blocks only the strobe. The status flags keep following the real occupancy, so software can prefill the FIFO while playback is stopped and then start it. Strobes are only raised while E is low.

Top module: `sample_fifo_player`

## Requirements
- R1: A write with `bus_addr`=0 pushes `bus_wdata` into the FIFO. A read with `bus_addr`=0 returns status in bits 1:0: bit 0 = FIFO empty and bit 1 = FIFO full, with the upper bits zero. The value is 1 when empty, 0 when partly filled and 2 when full.
- R2: A write with `bus_addr`=1 loads `bus_wdata[2:0]` into the control register, and a read with `bus_addr`=1 returns it in bits 2:0. Bit 2 = 1 halts playback. Bits 1:0 select the rate: 0 = 32 kHz, 1 = 16 kHz, 2 = 8 kHz, 3 = 7.2 kHz.
- R3: A push while the FIFO is full is dropped, and the stored samples are unchanged.
- R4: Samples appear on `dac_data` in write order. `dac_data` changes only on the clock edge that ends a strobe cycle with a non-empty FIFO.
- R5: While playback runs, strobes are exactly round(E_HZ / rate) E periods apart, where rate is the selected rate. Each strobe lasts one clock cycle.
- R6: `dac_strobe` is only ever high while `bus_e` is low.
- R7: While halted, no strobe occurs and no sample leaves the FIFO, but the status flags keep tracking the occupancy. Pushes can fill the FIFO to full, and re-enabling drains it to empty.
- R8: A strobe that meets an empty FIFO leaves `dac_data` at its last value.
- R9: Reset leaves the FIFO empty (status 1), `dac_data` at 0 and the control register at 7, which is halted at 7.2 kHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples the bus and E |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_e | input | 1 | Host bus clock E, sampled as a level |
| bus_sel | input | 1 | Block selected for a bus cycle |
| bus_we | input | 1 | Write strobe, one clock cycle per write |
| bus_addr | input | 1 | 0 = data/status port, 1 = control register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| dac_data | output | 8 | Current sample driven to the DAC |
| dac_strobe | output | 1 | Shift-out strobe, high for one cycle per sample period |

## Verification
The assertions check several rules on every cycle:
- the strobe is confined to E-low;
- the strobe is absent while halted and never lasts more than one cycle;
- a push into a full FIFO keeps it full;
- empty and full are never both set;
- the DAC output holds steady unless a strobe meets a non-empty FIFO.

Only the bench scenarios can show the rest. These are the FIFO ordering of samples, the exact strobe spacing for each of the four rate selections, prefilling to full while halted and then draining on re-enable, and the hold of the last sample when an empty FIFO is popped.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

   typedef enum logic [1:0] {
      RATE_32K = 2'd0,
      RATE_16K = 2'd1,
      RATE_8K  = 2'd2,
      RATE_7K2 = 2'd3
   } rate_e;

   typedef struct packed {
      logic  halt;
      rate_e rate;
   } ctrl_t;

   localparam ctrl_t CTRL_RESET = '{halt: 1'b1, rate: RATE_7K2};

   function automatic int unsigned rate_hz(input int unsigned idx);
      case (idx)
         0:       return 32000;
         1:       return 16000;
         2:       return 8000;
         default: return 7200;
      endcase
   endfunction

   // nearest integer number of E periods per sample
   function automatic int unsigned rate_tc(input int unsigned e_hz, input int unsigned idx);
      return (e_hz + rate_hz(idx) / 2) / rate_hz(idx);
   endfunction

endpackage

// File: rtl/sfp_fifo.sv
module sfp_fifo #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic          empty,
   output logic          full
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("sfp_fifo: DEPTH must be at least 2");
   end
   if (DW < 1) begin : g_bad_width
      $error("sfp_fifo: DW must be at least 1");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0] level;
   logic          push_ok, pop_ok;

   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign empty   = (level == '0);
   assign full    = (level == CW'(DEPTH));
   assign head    = mem[rd_ptr];

   if ((1 << AW) == DEPTH) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/sfp_rate_gen.sv
module sfp_rate_gen
   import sfp_pkg::*;
#(
   parameter int unsigned E_HZ = 1000000
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  bus_e,
   input  logic  enable,
   input  rate_e sel,
   input  logic  restart,
   output logic  strobe
);
   localparam int unsigned TC_MAX = rate_tc(E_HZ, 3);
   localparam int unsigned CW     = $clog2(TC_MAX + 1);

   if (rate_tc(E_HZ, 0) < 2) begin : g_bad_clock
      $error("sfp_rate_gen: E_HZ too low for the fastest rate");
   end

   logic [CW-1:0] tc_lut [4];
   for (genvar g = 0; g < 4; g++) begin : g_tc
      assign tc_lut[g] = CW'(rate_tc(E_HZ, g));
   end

   logic [CW-1:0] cnt;
   logic          e_q, pend, e_fall;

   assign e_fall = e_q && !bus_e;
   assign strobe = pend && !bus_e && enable;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         e_q  <= 1'b1;
         cnt  <= '0;
         pend <= 1'b0;
      end else begin
         e_q <= bus_e;
         if (restart || !enable) begin
            cnt  <= '0;
            pend <= 1'b0;
         end else begin
            if (strobe) pend <= 1'b0;
            if (e_fall) begin
               if (cnt == tc_lut[sel] - CW'(1)) begin
                  cnt  <= '0;
                  pend <= 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/sfp_bus_regs.sv
module sfp_bus_regs
   import sfp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_sel,
   input  logic       bus_we,
   input  logic       bus_addr,
   input  logic [7:0] bus_wdata,
   input  logic       fifo_empty,
   input  logic       fifo_full,
   output logic       push,
   output logic       ctrl_wr,
   output ctrl_t      ctrl,
   output logic [7:0] bus_rdata
);
   assign push    = bus_sel && bus_we && !bus_addr;
   assign ctrl_wr = bus_sel && bus_we && bus_addr;

   always_ff @(posedge clk) begin
      if (!rst_n)       ctrl <= CTRL_RESET;
      else if (ctrl_wr) ctrl <= ctrl_t'(bus_wdata[2:0]);
   end

   always_comb begin
      if (bus_addr) bus_rdata = {5'b0, ctrl};
      else          bus_rdata = {6'b0, fifo_full, fifo_empty};
   end
endmodule

// File: rtl/sample_fifo_player.sv
module sample_fifo_player
   import sfp_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned E_HZ  = 1000000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_e,
   input  logic       bus_sel,
   input  logic       bus_we,
   input  logic       bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic [7:0] dac_data,
   output logic       dac_strobe
);
   logic       fifo_empty, fifo_full, push_req, ctrl_wr, halt;
   logic [7:0] fifo_head;
   ctrl_t      ctrl_q;

   assign halt = ctrl_q.halt;

   sfp_bus_regs u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_sel    (bus_sel),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .fifo_empty (fifo_empty),
      .fifo_full  (fifo_full),
      .push       (push_req),
      .ctrl_wr    (ctrl_wr),
      .ctrl       (ctrl_q),
      .bus_rdata  (bus_rdata)
   );

   sfp_fifo #(.DW(8), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_req),
      .wdata (bus_wdata),
      .pop   (dac_strobe),
      .head  (fifo_head),
      .empty (fifo_empty),
      .full  (fifo_full)
   );

   sfp_rate_gen #(.E_HZ(E_HZ)) u_rate (
      .clk     (clk),
      .rst_n   (rst_n),
      .bus_e   (bus_e),
      .enable  (!halt),
      .sel     (ctrl_q.rate),
      .restart (ctrl_wr),
      .strobe  (dac_strobe)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                         dac_data <= '0;
      else if (dac_strobe && !fifo_empty) dac_data <= fifo_head;
   end
endmodule

// File: rtl/sample_fifo_player_chk.sv
module sample_fifo_player_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_e,
   input logic       halt,
   input logic       push_req,
   input logic       fifo_empty,
   input logic       fifo_full,
   input logic       dac_strobe,
   input logic [7:0] dac_data
);
   p_strobe_e_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dac_strobe |-> !bus_e);

   p_no_strobe_halted_r7: assert property (@(posedge clk) disable iff (!rst_n)
      halt |-> !dac_strobe);

   p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dac_strobe |=> !dac_strobe);

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_full && push_req && !dac_strobe) |=> fifo_full);

   p_flags_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_empty && fifo_full));

   p_dac_moves_on_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_strobe |=> $stable(dac_data));

   p_empty_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_empty |=> $stable(dac_data));
endmodule

bind sample_fifo_player sample_fifo_player_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_e      (bus_e),
   .halt       (halt),
   .push_req   (push_req),
   .fifo_empty (fifo_empty),
   .fifo_full  (fifo_full),
   .dac_strobe (dac_strobe),
   .dac_data   (dac_data)
);

// File: tb/sample_fifo_player_bench.sv
`timescale 1ns/1ps
module sample_fifo_player_bench;
   localparam int unsigned DEPTH = 8;
   localparam int unsigned E_HZ  = 64000;
   localparam int unsigned EPER  = 4;   // clk cycles per E period

   logic       clk = 1'b0, rst_n = 1'b0, bus_e = 1'b1;
   logic       bus_sel = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata, dac_data;
   logic       dac_strobe;

   int checks = 0, errors = 0, cyc = 0;
   bit stopped = 1'b1, done = 1'b0;

   sample_fifo_player #(.DEPTH(DEPTH), .E_HZ(E_HZ)) u_sample_fifo_player (
      .clk(clk), .rst_n(rst_n), .bus_e(bus_e), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .dac_data(dac_data), .dac_strobe(dac_strobe)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   initial begin
      forever begin
         repeat (2) @(negedge clk);
         bus_e = ~bus_e;
      end
   end

   function automatic int exp_tc(input int sel);
      int r;
      case (sel)
         0: r = 32000; 1: r = 16000; 2: r = 8000; default: r = 7200;
      endcase
      return (E_HZ + r / 2) / r;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // strobe monitor: R6 and R7 on every strobe
   always @(posedge clk) begin
      #1;
      if (rst_n && dac_strobe) begin
         check(!bus_e, "R6 strobe in E low", int'(bus_e), 0);
         if (stopped) check(1'b0, "R7 strobe while halted", 1, 0);
      end
   end

   task automatic wr(input bit a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input bit a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wait_strobe(output int c);
      int n = 0;
      do begin
         @(posedge clk); #1; n++;
      end while (!dac_strobe && n < 5000);
      if (!dac_strobe) check(1'b0, "R5 strobe timeout", n, 0);
      c = cyc;
   endtask

   initial begin
      int t0, t1, t2;
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      logic [7:0] v;
      int c_prev, c_now;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R9 reset state
      rd(0, v); check(v == 8'd1, "R9 reset status", v, 1);
      rd(1, v); check(v == 8'd7, "R9 reset control", v, 7);
      check(dac_data == 8'd0, "R9 reset dac", dac_data, 0);
      repeat (200) @(negedge clk);

      // R1/R7/R3: fill while halted, sweep status at every level, one extra push dropped
      for (int i = 0; i <= DEPTH; i++) begin
         wr(0, 8'hA0 + 8'(i));
         rd(0, v);
         check(v == ((i + 1 >= DEPTH) ? 8'd2 : 8'd0), "R1 R7 status while filling", v,
               (i + 1 >= DEPTH) ? 2 : 0);
      end
      check(dac_data == 8'd0, "R7 no pop while halted", dac_data, 0);

      // R2: control readback
      stopped = 1'b0;
      wr(1, 8'h00);
      rd(1, v); check(v == 8'd0, "R2 control readback", v, 0);

      // R4/R5: drain in order at 32 kHz, then the dropped byte must not appear (R3)
      c_prev = 0;
      for (int k = 0; k < DEPTH; k++) begin
         wait_strobe(c_now);
         @(posedge clk); #1;
         check(dac_data == 8'hA0 + 8'(k), "R4 R3 sample order", dac_data, 8'hA0 + k);
         if (k > 0)
            check(c_now - c_prev == exp_tc(0) * EPER, "R5 32k spacing", c_now - c_prev,
                  exp_tc(0) * EPER);
         c_prev = c_now;
      end
      rd(0, v); check(v == 8'd1, "R7 drained to empty", v, 1);

      // R8: strobe on empty FIFO holds last value
      wait_strobe(c_now);
      @(posedge clk); #1;
      check(dac_data == 8'hA0 + 8'(DEPTH - 1), "R8 hold on empty", dac_data, 8'hA0 + DEPTH - 1);

      // R5: sweep all rate selections
      for (int s = 0; s < 4; s++) begin
         wr(1, 8'(s));
         wait_strobe(c_prev);
         wait_strobe(c_prev);
         wait_strobe(c_now);
         check(c_now - c_prev == exp_tc(s) * EPER, "R5 rate spacing", c_now - c_prev,
               exp_tc(s) * EPER);
      end

      // R7: halt, push a few, flags track, nothing leaves
      wr(1, 8'h04);
      stopped = 1'b1;
      for (int i = 0; i < 3; i++) wr(0, 8'h50 + 8'(i));
      repeat (300) @(negedge clk);
      rd(0, v); check(v == 8'd0, "R7 partial while halted", v, 0);
      check(dac_data == 8'hA0 + 8'(DEPTH - 1), "R7 dac frozen while halted", dac_data,
            8'hA0 + DEPTH - 1);
      stopped = 1'b0;
      wr(1, 8'h01);
      for (int k = 0; k < 3; k++) begin
         wait_strobe(c_now);
         @(posedge clk); #1;
         check(dac_data == 8'h50 + 8'(k), "R4 R7 drain after re-enable", dac_data, 8'h50 + k);
      end
      rd(0, v); check(v == 8'd1, "R7 empty after re-enable", v, 1);

      finish_run();
   end
endmodule